// File: doc/BRIEF.md
# Reversible-Cell Ripple Adder/Subtractor

This block adds or subtracts two N-bit operands (default 32) with a ripple chain of identical four-input, four-output cells. Each cell behaves like a reversible gate: it keeps as many outputs as inputs. One control input selects whether the cell works as a full adder or as a full subtractor, and one shared mode bit drives that input in every slice. Each cell's carry/borrow output feeds the chained input of the next cell directly, with no logic in between. The block is purely combinational.

In subtract mode the cell's borrow output inverts the sense of its chained input. The chain therefore alternates polarity. Even slices receive a true borrow and pass on an inverted borrow. Odd slices receive that inverted borrow and restore the true sense. The operand bits are inverted on the matching parity, the difference bits of even slices are inverted back, and the final borrow is corrected when the last slice is even. The two non-arithmetic outputs of every cell are brought out on a garbage bus so that the chain's internal carries can be observed.

Top module: `rev_addsub`

## Requirements
- R1: A single cell with inputs (ctl, b, c, d) always gives p = b and s = b ^ c ^ d, in both modes.
- R2: With ctl = 0 the cell gives r = 1 exactly when at least two of b, c, d are 1, and q = c.
- R3: With ctl = 1 the cell gives r = 1 exactly when c + d > b, which is the borrow of b − c − d, and q = ~d.
- R4: With sub_mode = 0, {carry_out, result} equals op_x + op_y + carry_in.
- R5: With sub_mode = 1, result equals (op_x − op_y − carry_in) modulo 2^WIDTH.
- R6: With sub_mode = 1, carry_out is 1 exactly when op_x < op_y + carry_in, computed as unsigned values.
- R7: With sub_mode = 0, garbage bit 2i holds the carry into bit i (bit 0 holds carry_in), and garbage bit 2i+1 holds op_x[i].
- R8: With sub_mode = 1, garbage bit 2i holds the borrow into bit i, inverted when i is odd, and garbage bit 2i+1 holds op_y[i], inverted when i is odd.
- R9: The extreme operands give correct edge results: an all-ones operand plus a 1 wraps to zero with carry_out = 1, and 0 − 1 gives all ones with carry_out = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | WIDTH | First operand (minuend in subtract mode) |
| op_y | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 selects add, 1 selects subtract |
| carry_in | input | 1 | Carry-in in add mode, borrow-in in subtract mode |
| result | output | WIDTH | Sum or difference |
| carry_out | output | 1 | Carry-out in add mode, borrow-out in subtract mode |
| garbage | output | 2*WIDTH | Pairs {q, p} of every cell, cell i at bits 2i+1:2i |

## Verification
The assertions are immediate checks evaluated whenever an input changes. They assume that every input is a settled 0 or 1 whenever it is evaluated, and that sub_mode and carry_in are single bits with no unknown state. The stimulus meets these conditions: the bench drives all inputs together at a falling clock edge from known values, starting at zero, and samples the outputs one nanosecond later. Operands are exhaustive for the lone cell, and for the chain they are either chosen corner values or pseudo-random words, always fully defined.

// File: rtl/rac_pkg.sv
package rac_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic ctl;
        logic b;
        logic c;
        logic d;
    } cell_in_t;

    typedef struct packed {
        logic p;
        logic q;
        logic r;
        logic s;
    } cell_out_t;

    // Four-in, four-out cell: p passes b, q and r depend on ctl.
    function automatic cell_out_t cell_eval(input cell_in_t i);
        cell_out_t o;
        o.p = i.b;
        o.q = (~i.ctl & i.c) | (i.ctl & ~i.d);
        o.r = ((i.ctl ^ i.b) & (i.c ^ i.d)) ^ (i.c & i.d);
        o.s = i.b ^ i.c ^ i.d;
        return o;
    endfunction

    // Whether a slice index is odd; decides operand and output inversion.
    function automatic logic slice_is_odd(input int idx);
        return (idx % 2) == 1;
    endfunction

endpackage

// File: rtl/rac_cell.sv
module rac_cell
    import rac_pkg::*;
(
    input  logic ctl,
    input  logic b,
    input  logic c,
    input  logic d,
    output logic p,
    output logic q,
    output logic r,
    output logic s
);
    cell_in_t  cin_s;
    cell_out_t cout_s;

    always_comb begin
        cin_s  = '{ctl: ctl, b: b, c: c, d: d};
        cout_s = cell_eval(cin_s);
    end

    assign p = cout_s.p;
    assign q = cout_s.q;
    assign r = cout_s.r;
    assign s = cout_s.s;
endmodule

// File: rtl/rac_slice.sv
module rac_slice
    import rac_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic mode_sub,
    input  logic x_bit,
    input  logic y_bit,
    input  logic link_in,
    output logic link_out,
    output logic res_bit,
    output logic [1:0] junk
);
    localparam logic ODD  = slice_is_odd(IDX);
    localparam logic EVEN = ~ODD;

    logic c_in, d_in, p_o, q_o, s_o;

    // In subtract mode odd slices invert x, even slices invert y.
    assign c_in = x_bit ^ (mode_sub & ODD);
    assign d_in = y_bit ^ (mode_sub & EVEN);

    rac_cell u_cell (
        .ctl (mode_sub),
        .b   (link_in),
        .c   (c_in),
        .d   (d_in),
        .p   (p_o),
        .q   (q_o),
        .r   (link_out),
        .s   (s_o)
    );

    assign res_bit = s_o ^ (mode_sub & EVEN);
    assign junk    = {q_o, p_o};
endmodule

// File: rtl/rac_chain.sv
module rac_chain
    import rac_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             mode_sub,
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             link0,
    output logic [WIDTH-1:0] sum,
    output logic             link_last,
    output logic [2*WIDTH-1:0] junk
);
    logic [WIDTH:0] link;

    assign link[0] = link0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        rac_slice #(.IDX(i)) u_slice (
            .mode_sub (mode_sub),
            .x_bit    (x[i]),
            .y_bit    (y[i]),
            .link_in  (link[i]),
            .link_out (link[i+1]),
            .res_bit  (sum[i]),
            .junk     (junk[2*i+1:2*i])
        );
    end

    assign link_last = link[WIDTH];
endmodule

// File: rtl/rev_addsub.sv
module rev_addsub
    import rac_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   op_x,
    input  logic [WIDTH-1:0]   op_y,
    input  logic               sub_mode,
    input  logic               carry_in,
    output logic [WIDTH-1:0]   result,
    output logic               carry_out,
    output logic [2*WIDTH-1:0] garbage
);
    localparam logic LAST_EVEN = ~slice_is_odd(WIDTH - 1);

    op_mode_e mode;
    logic     sub_en;
    logic     tail;

    assign mode   = op_mode_e'(sub_mode);
    assign sub_en = (mode == OP_SUB);

    rac_chain #(.WIDTH(WIDTH)) u_chain (
        .mode_sub  (sub_en),
        .x         (op_x),
        .y         (op_y),
        .link0     (carry_in),
        .sum       (result),
        .link_last (tail),
        .junk      (garbage)
    );

    // An even last slice hands out an inverted borrow.
    assign carry_out = tail ^ (sub_en & LAST_EVEN);
endmodule

// File: rtl/rev_addsub_chk.sv
module rev_addsub_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0]   op_x,
    input logic [WIDTH-1:0]   op_y,
    input logic               sub_mode,
    input logic               carry_in,
    input logic [WIDTH-1:0]   result,
    input logic               carry_out,
    input logic [2*WIDTH-1:0] garbage
);
    logic [WIDTH:0] ref_add;
    logic [WIDTH:0] ref_sub;
    logic [WIDTH:0] ref_rhs;

    always_comb begin
        ref_add = {1'b0, op_x} + {1'b0, op_y} + {{WIDTH{1'b0}}, carry_in};
        ref_sub = {1'b0, op_x} - {1'b0, op_y} - {{WIDTH{1'b0}}, carry_in};
        ref_rhs = {1'b0, op_y} + {{WIDTH{1'b0}}, carry_in};

        // R4
        add_sum_chk: assert (sub_mode || ({carry_out, result} == ref_add));
        // R5
        sub_diff_chk: assert (!sub_mode || (result == ref_sub[WIDTH-1:0]));
        // R6
        sub_borrow_chk: assert (!sub_mode || (carry_out == ({1'b0, op_x} < ref_rhs)));
        // R7
        chain_entry_chk: assert (garbage[0] == carry_in);
        // R7
        add_q_pass_chk: assert (sub_mode || (garbage[1] == op_x[0]));
    end
endmodule

bind rev_addsub rev_addsub_chk #(.WIDTH(WIDTH)) u_chk (
    .op_x      (op_x),
    .op_y      (op_y),
    .sub_mode  (sub_mode),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out),
    .garbage   (garbage)
);

// File: tb/tb_rev_addsub.sv
`timescale 1ns/1ps
module tb_rev_addsub;
    localparam int W = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0]   op_x = '0, op_y = '0;
    logic           sub_mode = 1'b0, carry_in = 1'b0;
    logic [W-1:0]   result;
    logic           carry_out;
    logic [2*W-1:0] garbage;

    logic cc = 0, cb = 0, cx = 0, cy = 0;
    logic cp, cq, cr, cs;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    rev_addsub #(.WIDTH(W)) dut (
        .op_x(op_x), .op_y(op_y), .sub_mode(sub_mode), .carry_in(carry_in),
        .result(result), .carry_out(carry_out), .garbage(garbage)
    );

    rac_cell u_cell (
        .ctl(cc), .b(cb), .c(cx), .d(cy),
        .p(cp), .q(cq), .r(cr), .s(cs)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic m, input logic ci);
        @(negedge clk);
        op_x = x; op_y = y; sub_mode = m; carry_in = ci;
        #1;
    endtask

    // Full expected behaviour of the chain, derived from arithmetic.
    task automatic check_op(input logic [W-1:0] x, input logic [W-1:0] y,
                            input logic m, input logic ci);
        logic [63:0] ext;
        logic [W:0]  links;
        logic [2*W-1:0] g;
        apply(x, y, m, ci);
        if (!m) begin
            ext = {32'd0, x} + {32'd0, y} + {63'd0, ci};
            chk("R4 sum", {31'd0, carry_out, result}, {31'd0, ext[32:0]});
            links = ext[W:0] ^ {1'b0, x} ^ {1'b0, y};
            for (int i = 0; i < W; i++) g[2*i +: 2] = {x[i], links[i]};
            chk("R7 garbage", garbage, g);
        end else begin
            ext = {32'd0, x} - {32'd0, y} - {63'd0, ci};
            chk("R5 difference", {32'd0, result}, {32'd0, ext[31:0]});
            chk("R6 borrow", {63'd0, carry_out},
                {63'd0, ({32'd0, x} < ({32'd0, y} + {63'd0, ci}))});
            links = ext[W:0] ^ {1'b0, x} ^ {1'b0, y};
            for (int i = 0; i < W; i++) begin
                logic odd;
                odd = (i % 2) == 1;
                g[2*i +: 2] = {y[i] ^ odd, links[i] ^ odd};
            end
            chk("R8 garbage", garbage, g);
        end
    endtask

    task automatic test_reset_state();
        @(negedge clk); #1;
        chk("R4 idle zero", {31'd0, carry_out, result}, 64'd0);
        chk("R7 idle garbage", garbage, 64'd0);
    endtask

    task automatic test_cell_table();
        for (int n = 0; n < 16; n++) begin
            logic a, b, c, d, er, eq;
            {a, b, c, d} = 4'(n);
            @(negedge clk);
            cc = a; cb = b; cx = c; cy = d;
            #1;
            chk("R1 cell p", {63'd0, cp}, {63'd0, b});
            chk("R1 cell s", {63'd0, cs}, {63'd0, b ^ c ^ d});
            if (!a) begin
                er = (int'(b) + int'(c) + int'(d)) >= 2;
                eq = c;
                chk("R2 cell r", {63'd0, cr}, {63'd0, er});
                chk("R2 cell q", {63'd0, cq}, {63'd0, eq});
            end else begin
                er = (int'(c) + int'(d)) > int'(b);
                eq = ~d;
                chk("R3 cell r", {63'd0, cr}, {63'd0, er});
                chk("R3 cell q", {63'd0, cq}, {63'd0, eq});
            end
        end
    endtask

    task automatic test_add_patterns();
        check_op(32'd5, 32'd7, 1'b0, 1'b0);
        check_op(32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b0, 1'b1);
        check_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);
        for (int k = 0; k < 200; k++) check_op($urandom, $urandom, 1'b0, 1'($urandom));
    endtask

    task automatic test_sub_patterns();
        check_op(32'd100, 32'd37, 1'b1, 1'b0);
        check_op(32'd37, 32'd100, 1'b1, 1'b1);
        check_op(32'd9, 32'd9, 1'b1, 1'b0);
        check_op(32'd9, 32'd8, 1'b1, 1'b1);
        check_op(32'd9, 32'd9, 1'b1, 1'b1);
        for (int k = 0; k < 200; k++) check_op($urandom, $urandom, 1'b1, 1'($urandom));
    endtask

    task automatic test_edges();
        apply('1, 32'd1, 1'b0, 1'b0);
        chk("R9 wrap add", {31'd0, carry_out, result}, {31'd0, 1'b1, 32'd0});
        apply('1, '0, 1'b0, 1'b1);
        chk("R9 wrap cin", {31'd0, carry_out, result}, {31'd0, 1'b1, 32'd0});
        apply('0, 32'd1, 1'b1, 1'b0);
        chk("R9 under sub", {31'd0, carry_out, result}, {31'd0, 1'b1, 32'hFFFF_FFFF});
        apply('0, '0, 1'b1, 1'b1);
        chk("R9 under bin", {31'd0, carry_out, result}, {31'd0, 1'b1, 32'hFFFF_FFFF});
        apply('1, '1, 1'b1, 1'b0);
        chk("R9 equal max", {31'd0, carry_out, result}, 64'd0);
        check_op('1, '1, 1'b0, 1'b1);
        check_op('0, '1, 1'b1, 1'b1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        test_reset_state();
        test_cell_table();
        test_add_patterns();
        test_sub_patterns();
        test_edges();
        finish_run();
    end
endmodule